// File: doc/BRIEF.md
# Multi-Mode Programmable Logic Cell

This block models one configurable logic cell of the kind tiled inside a programmable logic array. Static configuration inputs select one of three operating modes, hold a 16-entry truth table, pick the cascade operator and choose between a registered and a combinational main output. In general-logic mode the whole table acts as one 4-input lookup. In arithmetic and counter modes it splits into two 3-input lookups. One half gives the data bit and the other gives the fast carry for the next cell.

Cells chain through dedicated carry and cascade ports. A column of cells configured for arithmetic forms a ripple adder. The same column configured for counting forms an up/down counter with enable. Cascading lets the lookup results of several cells be merged into one wide AND or OR. Synchronous clear and synchronous load are meant to be wired to every cell of a group at once. They act on the cell's single flip-flop with a fixed priority.

Top module: `plc_cell`

## Requirements
- R1: In general mode (`cfg_mode` 0, or the unused code 3), the lookup index is `{x, din[2], din[1], din[0]}` into `cfg_lut[15:0]`, where `x` is `cin` when `cfg_cin_sel` is 1 and `din[3]` otherwise.
- R2: The cascade result is the lookup data bit combined with `casc_in` by AND when `cfg_casc_or` is 0, or by OR when it is 1. It drives `casc_out` in every mode, and it drives `dout` when `cfg_comb` is 1. The neutral `casc_in` value is 1 for AND and 0 for OR.
- R3: In arithmetic mode (`cfg_mode` 1), with index `i = {cin, din[1], din[0]}`, the data bit is `cfg_lut[i]` and `cout` is `cfg_lut[8+i]`.
- R4: In general mode, `cout` is 0.
- R5: With `cfg_comb` 0, `dout` shows the flip-flop. On each rising `clk` edge, with no clear, no load and no hold, the flip-flop takes the cascade result.
- R6: In counter mode (`cfg_mode` 2), `din[0]` is count enable and `din[1]` is direction (1 = up). With index `i = {cin, q, din[1]}`, the data bit is `cfg_lut[i]` and `cout` is `cfg_lut[8+i]`. When `din[0]` is 0, the flip-flop keeps its value.
- R7: `sload` high loads `din[3]` into the flip-flop on the next edge, in any mode, overriding the enable and the cascade result.
- R8: `sclr` high clears the flip-flop on the next edge and wins over `sload`.
- R9: `rst_n` low clears the flip-flop at once, without waiting for a clock.
- R10: Eight chained cells form an 8-bit adder with the table 16'hE896, or an 8-bit wrapping up/down counter with the table 16'h903C and the first `cin` tied to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the cell flip-flop |
| rst_n | input | 1 | Asynchronous active-low reset of the flip-flop |
| cfg_mode | input | 2 | Operating mode: 0 general, 1 arithmetic, 2 counter, 3 general |
| cfg_lut | input | 16 | Truth table; the low half is data and the high half is carry in split modes |
| cfg_cin_sel | input | 1 | General mode: uses carry-in as the fourth lookup input |
| cfg_casc_or | input | 1 | Cascade operator: 0 AND, 1 OR |
| cfg_comb | input | 1 | 1 makes `dout` combinational, 0 makes it registered |
| din | input | 4 | Data inputs; in counter mode bit 0 is enable and bit 1 is direction; bit 3 is the load value |
| cin | input | 1 | Carry from the previous cell |
| casc_in | input | 1 | Cascade value from the previous cell |
| sclr | input | 1 | Group-wide synchronous clear |
| sload | input | 1 | Group-wide synchronous load |
| dout | output | 1 | Main output |
| cout | output | 1 | Carry to the next cell |
| casc_out | output | 1 | Cascade value to the next cell |

## Verification
The flip-flop is the cell's only state. With a registered output, a wrong value in it appears on `dout` one edge after the fault. In counter mode it also feeds the lookup index, so the error spreads through `cout` into every higher cell of the chain on the very next count. A wrong priority among clear, load and hold shows on the edge right after both controls are raised together. A wrong table split or index order shows at once on the combinational sum and carry outputs of the chained adder.

// File: rtl/plc_pkg.sv
package plc_pkg;
   typedef enum logic [1:0] {
      PLC_GENERAL = 2'b00,
      PLC_ARITH   = 2'b01,
      PLC_COUNT   = 2'b10,
      PLC_SPARE   = 2'b11
   } plc_mode_e;

   // neutral cascade value for the selected operator
   function automatic logic casc_neutral(input logic use_or);
      return !use_or;
   endfunction
endpackage

// File: rtl/plc_lut.sv
module plc_lut #(
   parameter int K = 4
) (
   input  logic [(2**K)-1:0] table_bits,
   input  logic [K-1:0]      sel,
   output logic              y
);
   localparam int LEAVES = 2**K;
   localparam int NODES  = 2*LEAVES - 1;

   if (K < 1) begin : g_bad_k
      $error("plc_lut: K must be at least 1");
   end

   logic [NODES-1:0] node;

   for (genvar m = 0; m < LEAVES; m++) begin : g_leaf
      assign node[LEAVES-1+m] = table_bits[m];
   end

   for (genvar d = 0; d < K; d++) begin : g_level
      for (genvar n = 0; n < 2**d; n++) begin : g_mux
         localparam int J = (2**d) - 1 + n;
         assign node[J] = sel[K-1-d] ? node[2*J+2] : node[2*J+1];
      end
   end

   assign y = node[0];
endmodule

// File: rtl/plc_casc.sv
module plc_casc (
   input  logic use_or,
   input  logic d,
   input  logic c,
   output logic y
);
   always_comb begin
      if (use_or) y = d | c;
      else        y = d & c;
   end
endmodule

// File: rtl/plc_reg.sv
module plc_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic sclr,
   input  logic sload,
   input  logic ld_val,
   input  logic hold,
   input  logic d,
   output logic q
);
   logic nxt;

   // clear, then load, then hold, then cascade result
   always_comb begin
      if (sclr)       nxt = 1'b0;
      else if (sload) nxt = ld_val;
      else if (hold)  nxt = q;
      else            nxt = d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end
endmodule

// File: rtl/plc_cell.sv
module plc_cell #(
   parameter int LUT_K = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cfg_mode,
   input  logic [(2**LUT_K)-1:0] cfg_lut,
   input  logic                 cfg_cin_sel,
   input  logic                 cfg_casc_or,
   input  logic                 cfg_comb,
   input  logic [LUT_K-1:0]     din,
   input  logic                 cin,
   input  logic                 casc_in,
   input  logic                 sclr,
   input  logic                 sload,
   output logic                 dout,
   output logic                 cout,
   output logic                 casc_out
);
   import plc_pkg::*;

   localparam int SPLIT_K = LUT_K - 1;
   localparam int HALF    = 2**SPLIT_K;

   if (LUT_K < 4 || LUT_K > 6) begin : g_bad_width
      $error("plc_cell: LUT_K must lie in 4..6");
   end

   plc_mode_e mode;
   assign mode = plc_mode_e'(cfg_mode);

   logic is_split, is_count;
   assign is_count = (mode == PLC_COUNT);
   assign is_split = (mode == PLC_ARITH) || is_count;

   logic q;

   // full-width lookup for general mode
   logic              top_in;
   logic [LUT_K-1:0]  full_idx;
   logic              full_y;
   assign top_in   = cfg_cin_sel ? cin : din[LUT_K-1];
   assign full_idx = {top_in, din[LUT_K-2:0]};

   plc_lut #(.K(LUT_K)) u_full (
      .table_bits (cfg_lut),
      .sel        (full_idx),
      .y          (full_y)
   );

   // split lookups share one index
   logic [SPLIT_K-1:0] split_idx;
   logic               data_y, carry_y;
   always_comb begin
      if (is_count) split_idx = {cin, q, din[SPLIT_K-2:1]};
      else          split_idx = {cin, din[SPLIT_K-2:0]};
   end

   plc_lut #(.K(SPLIT_K)) u_data (
      .table_bits (cfg_lut[HALF-1:0]),
      .sel        (split_idx),
      .y          (data_y)
   );

   plc_lut #(.K(SPLIT_K)) u_carry (
      .table_bits (cfg_lut[2*HALF-1:HALF]),
      .sel        (split_idx),
      .y          (carry_y)
   );

   logic lut_bit, casc_val;
   assign lut_bit = is_split ? data_y : full_y;

   plc_casc u_casc (
      .use_or (cfg_casc_or),
      .d      (lut_bit),
      .c      (casc_in),
      .y      (casc_val)
   );

   plc_reg u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclr   (sclr),
      .sload  (sload),
      .ld_val (din[LUT_K-1]),
      .hold   (is_count && !din[0]),
      .d      (casc_val),
      .q      (q)
   );

   assign casc_out = casc_val;
   assign cout     = is_split ? carry_y : 1'b0;
   assign dout     = cfg_comb ? casc_val : q;
endmodule

// File: rtl/plc_cell_chk.sv
module plc_cell_chk #(
   parameter int LUT_K = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cfg_mode,
   input logic             cfg_casc_or,
   input logic             cfg_comb,
   input logic [LUT_K-1:0] din,
   input logic             casc_in,
   input logic             sclr,
   input logic             sload,
   input logic             dout,
   input logic             cout,
   input logic             casc_out
);
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (sclr && !cfg_comb) |=> (cfg_comb || !dout)); // R8

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclr && sload && !cfg_comb) |=> (cfg_comb || dout == $past(din[LUT_K-1]))); // R7

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'b10 && !sclr && !sload && !din[0] && !cfg_comb)
      |=> (cfg_comb || $stable(dout))); // R6

   AST_GENERAL_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'b00 || cfg_mode == 2'b11) |-> !cout); // R4

   AST_CASC_AND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_casc_or && !casc_in) |-> !casc_out); // R2

   AST_CASC_OR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_casc_or && casc_in) |-> casc_out); // R2
endmodule

bind plc_cell plc_cell_chk #(.LUT_K(LUT_K)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_mode    (cfg_mode),
   .cfg_casc_or (cfg_casc_or),
   .cfg_comb    (cfg_comb),
   .din         (din),
   .casc_in     (casc_in),
   .sclr        (sclr),
   .sload       (sload),
   .dout        (dout),
   .cout        (cout),
   .casc_out    (casc_out)
);

// File: tb/plc_cell_bench.sv
`timescale 1ns/1ps
module plc_cell_bench;
   localparam int N = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b10;
   logic [15:0] lut = 16'h903C;
   logic        cin_sel = 1'b0, casc_or = 1'b0, comb = 1'b0;
   logic        sclr = 1'b0, sload = 1'b0, cin0 = 1'b1, casc0 = 1'b1, link = 1'b0;
   logic [N-1:0][3:0] din_t = '0;
   logic [N-1:0] dout, cout, cout_unused_chk, casc_out, cin_w, casc_w;

   int n_chk = 0, n_fail = 0, exp_cnt = 0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      if (i == 0) begin : g_first
         assign cin_w[i]  = cin0;
         assign casc_w[i] = link ? casc0 : !casc_or;
      end else begin : g_rest
         assign cin_w[i]  = cout[i-1];
         assign casc_w[i] = link ? casc_out[i-1] : !casc_or;
      end
      if (i == 0) begin : g_u
         plc_cell u_plc_cell (
            .clk(clk), .rst_n(rst_n), .cfg_mode(mode), .cfg_lut(lut),
            .cfg_cin_sel(cin_sel), .cfg_casc_or(casc_or), .cfg_comb(comb),
            .din(din_t[i]), .cin(cin_w[i]), .casc_in(casc_w[i]),
            .sclr(sclr), .sload(sload), .dout(dout[i]), .cout(cout[i]),
            .casc_out(casc_out[i]));
      end else begin : g_c
         plc_cell u_cell (
            .clk(clk), .rst_n(rst_n), .cfg_mode(mode), .cfg_lut(lut),
            .cfg_cin_sel(cin_sel), .cfg_casc_or(casc_or), .cfg_comb(comb),
            .din(din_t[i]), .cin(cin_w[i]), .casc_in(casc_w[i]),
            .sclr(sclr), .sload(sload), .dout(dout[i]), .cout(cout[i]),
            .casc_out(casc_out[i]));
      end
   end
   assign cout_unused_chk = '0;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_din(input logic [7:0] b3, input logic [7:0] b2,
                          input logic [7:0] b1, input logic [7:0] b0);
      for (int i = 0; i < N; i++) din_t[i] = {b3[i], b2[i], b1[i], b0[i]};
   endtask

   // counter step: drive, clock, update the model, compare
   task automatic tick(input string req, input bit c, input bit l, input bit e,
                       input bit up, input logic [7:0] ldv);
      @(negedge clk);
      sclr = c; sload = l;
      set_din(ldv, 8'h00, {N{up}}, {N{e}});
      @(posedge clk);
      if (c)      exp_cnt = 0;
      else if (l) exp_cnt = ldv;
      else if (e) exp_cnt = up ? (exp_cnt + 1) % 256 : (exp_cnt + 255) % 256;
      #1;
      chk(req, {8'h00, dout}, exp_cnt[15:0]);
   endtask

   task automatic add_vec(input logic [7:0] a, input logic [7:0] b, input bit c);
      logic [8:0] s;
      @(negedge clk);
      set_din(8'h00, 8'h00, b, a);
      cin0 = c;
      #1;
      s = {1'b0, a} + {1'b0, b} + {8'h00, c};
      chk("R3 R10 adder sum", {8'h00, dout}, {8'h00, s[7:0]});
      chk("R3 R10 adder carry", {15'h0, cout[N-1]}, {15'h0, s[8]});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (2) @(negedge clk);
      chk("R9 reset state", {8'h00, dout}, 16'h0000);
      rst_n = 1'b1;

      // R3, R10: combinational adder chain
      mode = 2'b01; lut = 16'hE896; comb = 1'b1; casc_or = 1'b0; link = 1'b0;
      add_vec(8'hFF, 8'h01, 1'b0);
      add_vec(8'hAA, 8'h55, 1'b1);
      add_vec(8'hC8, 8'h64, 1'b0);
      add_vec(8'h00, 8'h00, 1'b1);
      add_vec(8'h3C, 8'h0F, 1'b1);
      for (int k = 0; k < 4; k++) add_vec(8'($urandom), 8'($urandom), 1'($urandom));

      // R5: registered adder output
      comb = 1'b0;
      @(negedge clk); set_din(8'h00, 8'h00, 8'd4, 8'd3); cin0 = 1'b0;
      @(posedge clk); #1;
      chk("R5 registered sum", {8'h00, dout}, 16'd7);
      @(negedge clk); set_din(8'h00, 8'h00, 8'd20, 8'd10);
      #1;
      chk("R5 holds before edge", {8'h00, dout}, 16'd7);
      @(posedge clk); #1;
      chk("R5 registered sum next", {8'h00, dout}, 16'd30);

      // R1, R2: wide AND via cascade
      @(negedge clk);
      mode = 2'b00; comb = 1'b1; lut = 16'h8000; casc_or = 1'b0; link = 1'b1; casc0 = 1'b1;
      set_din(8'hFF, 8'hFF, 8'hFF, 8'hFF);
      #1;
      chk("R2 AND cascade all ones", {8'h00, casc_out}, 16'h00FF);
      set_din(8'hFF, 8'hFB, 8'hFF, 8'hFF);
      #1;
      chk("R2 AND cascade break at cell 2", {8'h00, casc_out}, 16'h0003);
      chk("R1 general dout", {8'h00, dout}, 16'h0003);

      // R2: wide OR via cascade
      lut = 16'hFFFE; casc_or = 1'b1; casc0 = 1'b0;
      set_din(8'h00, 8'h00, 8'h00, 8'h00);
      #1;
      chk("R2 OR cascade all zero", {8'h00, casc_out}, 16'h0000);
      set_din(8'h00, 8'h20, 8'h00, 8'h00);
      #1;
      chk("R2 OR cascade from cell 5", {8'h00, casc_out}, 16'h00E0);

      // R1, R4: fourth input select
      lut = 16'hFF00; casc_or = 1'b0; link = 1'b0; cin_sel = 1'b1; cin0 = 1'b1;
      set_din(8'h00, 8'h00, 8'h00, 8'h00);
      #1;
      chk("R1 carry-in as fourth input", {8'h00, dout}, 16'h0001);
      chk("R4 general mode carry low", {8'h00, cout}, 16'h0000);
      cin_sel = 1'b0; cin0 = 1'b0;
      set_din(8'hFF, 8'h00, 8'h00, 8'h00);
      #1;
      chk("R1 din3 as fourth input", {8'h00, dout}, 16'h00FF);
      mode = 2'b11;
      #1;
      chk("R1 spare code acts as general", {8'h00, dout}, 16'h00FF);

      // R7: load in general mode
      mode = 2'b00; comb = 1'b0;
      @(negedge clk); sload = 1'b1; set_din(8'h5A, 8'h00, 8'h00, 8'h00);
      @(posedge clk); #1;
      chk("R7 load in general mode", {8'h00, dout}, 16'h005A);

      // R6, R7, R8, R10: counter chain
      @(negedge clk);
      sload = 1'b0; mode = 2'b10; lut = 16'h903C; cin0 = 1'b1; casc_or = 1'b0;
      exp_cnt = 8'h5A;
      tick("R8 clear", 1, 0, 1, 1, 8'h00);
      for (int k = 0; k < 5; k++) tick("R6 count up", 0, 0, 1, 1, 8'h00);
      for (int k = 0; k < 3; k++) tick("R6 hold when disabled", 0, 0, 0, 1, 8'h00);
      for (int k = 0; k < 7; k++) tick("R10 count down with wrap", 0, 0, 1, 0, 8'h00);
      tick("R7 load over enable", 0, 1, 1, 1, 8'hA5);
      for (int k = 0; k < 2; k++) tick("R6 count up after load", 0, 0, 1, 1, 8'h00);
      tick("R8 clear wins over load", 1, 1, 1, 1, 8'hA5);
      tick("R7 load top value", 0, 1, 0, 1, 8'hFF);
      tick("R10 up wrap to zero", 0, 0, 1, 1, 8'h00);
      tick("R7 load pattern", 0, 1, 0, 1, 8'h3C);

      // R9: asynchronous reset between edges
      @(negedge clk);
      set_din(8'h00, 8'h00, 8'h00, 8'h00);
      rst_n = 1'b0;
      #1;
      chk("R9 async reset", {8'h00, dout}, 16'h0000);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule